// File: doc/BRIEF.md
# Zero-Crossing Soft Mute Controller

This block silences one channel of a signed audio sample stream in three ways. A direct mute zeroes the output at once. A soft mute scales the signal with an 8-bit gain that ramps down to silence and back up again. The ramp has a fast or a slow slope. A zero-crossing mute engages or releases only on a sample whose magnitude lies inside a programmable window around zero. The switch therefore never lands on a large sample and never causes a click.

Soft mute can be requested by a register bit or by an external active-low pin. The pin is resynchronised before use, and the two requests are ORed. Two status outputs report the soft mute and the zero-crossing mute. The output sample is registered and follows each valid input sample by one clock.

The zero-crossing state machine has four states:
- `ZC_OPEN`: not muted.
- `ZC_ARMING`: mute requested, waiting for a sample inside the window.
- `ZC_CLOSED`: muted.
- `ZC_RELEASING`: release requested, waiting for a sample inside the window.

Its transitions, each taken on a valid sample:
- OPEN to CLOSED when the mute request is set and the sample is inside the window.
- OPEN to ARMING when the request is set and the sample is outside the window.
- ARMING to CLOSED on a sample inside the window.
- ARMING to OPEN when the request drops.
- CLOSED to OPEN when the request drops and the sample is inside the window.
- CLOSED to RELEASING when the request drops and the sample is outside the window.
- RELEASING to OPEN on a sample inside the window.
- RELEASING to CLOSED when the request returns.
- The clear command forces OPEN from any state in any cycle.

The ramp state machine has four states:
- `SR_IDLE`: full gain, pass-through.
- `SR_FALL`: gain decreasing.
- `SR_HELD`: gain 0.
- `SR_RISE`: gain increasing.

Its transitions:
- IDLE to FALL on a request, in any cycle.
- FALL to HELD when the gain steps from 1 to 0.
- FALL to RISE and HELD to RISE when the request drops.
- RISE to FALL when the request returns.
- RISE to IDLE when the gain steps up to 255.

Top module: `zc_mute_ctrl`

## Requirements
- R1: After reset, `sample_out` is 0, `out_valid` is 0, `sm_active` is 0 and `zc_muted` is 0.
- R2: A sample lies inside the window when its magnitude, computed without overflow, is strictly below 1024 >> `win_sel`. The thresholds are 1024, 512, 256 and 128 for codes 0 to 3, and -32768 is never inside the window.
- R3: With `zc_req` set, `zc_muted` stays 0 and samples pass unchanged until a sample inside the window arrives. That sample is output as 0, and `zc_muted` is 1 from the next cycle.
- R4: With `zc_req` cleared while muted, `zc_muted` stays 1 and the output stays 0 for every sample outside the window. The first sample inside the window is passed unchanged, and `zc_muted` falls with it.
- R5: A `zc_clear` pulse returns the zero-crossing logic to the unmuted state on the next clock, whatever sample is present.
- R6: The soft mute request is `sm_req` OR a low `sm_pin_n`. The pin goes through two synchronising flops. `sm_active` is 1 on the clock after the internal request is seen.
- R7: During a soft mute, the gain starts at 255 and drops by one every 4 valid samples when `sm_slow` is 0, or every 64 when it is 1. The output is floor(x*gain/256), and it is 0 once the gain reaches 0.
- R8: When the soft mute request drops, the gain climbs at the same rate. When it returns to 255, `sm_active` falls and samples pass unchanged again.
- R9: A valid sample with `direct_mute` set is output as 0 on the next clock, with no wait for a crossing. It does not change `zc_muted` or `sm_active`.
- R10: With no mute active, `sample_out` equals the previous valid `sample_in`, and `out_valid` is `sample_valid` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Input sample strobe |
| sample_in | input | 16 | Signed input sample |
| sm_pin_n | input | 1 | Asynchronous active-low soft mute request |
| sm_req | input | 1 | Register soft mute request |
| sm_slow | input | 1 | Ramp slope: 0 fast, 1 slow |
| direct_mute | input | 1 | Immediate mute |
| zc_req | input | 1 | Zero-crossing mute request |
| win_sel | input | 2 | Window code, 0 widest to 3 narrowest |
| zc_clear | input | 1 | Reset zero-crossing logic to unmuted |
| sample_out | output | 16 | Signed output sample |
| out_valid | output | 1 | Output strobe |
| sm_active | output | 1 | Soft mute in effect (gain below full or ramping) |
| zc_muted | output | 1 | Zero-crossing mute in effect |

## Verification
The assertions assume that `sample_valid` is low throughout reset. They also assume that `zc_clear` is a pulse whose effect wins over a sample in the same cycle, and that control inputs change only between samples. The bench drives every input on the falling edge and raises `sample_valid` for one cycle at a time. It keeps `sample_valid` low during reset and never changes `win_sel` and `zc_req` together with a sample. Every property therefore sees stable control for the sample it reasons about.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

    typedef enum logic [1:0] {
        ZC_OPEN,
        ZC_ARMING,
        ZC_CLOSED,
        ZC_RELEASING
    } zc_state_e;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_FALL,
        SR_HELD,
        SR_RISE
    } ramp_state_e;

endpackage

// File: rtl/zcm_window.sv
module zcm_window #(
    parameter int DATA_W   = 16,
    parameter int WIN_BASE = 1024
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [1:0]        win_sel,
    output logic              in_win
);
    localparam int MAG_W = DATA_W + 1;

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] thr;

    always_comb begin
        ext    = {sample[DATA_W-1], sample};
        mag    = sample[DATA_W-1] ? (~ext + 1'b1) : ext;
        thr    = MAG_W'(WIN_BASE) >> win_sel;
        in_win = (mag < thr);
    end

    always_comb begin
        if (sample == '0) begin
            AST_ZERO_IN_WINDOW: assert (in_win); // R2
        end
    end
endmodule

// File: rtl/zcm_zc_fsm.sv
module zcm_zc_fsm
    import zcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_valid,
    input  logic in_win,
    input  logic zc_req,
    input  logic zc_clear,
    output logic zc_muted,
    output logic mute_now
);
    zc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (zc_clear) begin
            state_d = ZC_OPEN;
        end else if (sample_valid) begin
            unique case (state_q)
                ZC_OPEN:      if (zc_req) state_d = in_win ? ZC_CLOSED : ZC_ARMING;
                ZC_ARMING:    if (!zc_req) state_d = ZC_OPEN;
                              else if (in_win) state_d = ZC_CLOSED;
                ZC_CLOSED:    if (!zc_req) state_d = in_win ? ZC_OPEN : ZC_RELEASING;
                ZC_RELEASING: if (zc_req) state_d = ZC_CLOSED;
                              else if (in_win) state_d = ZC_OPEN;
                default:      state_d = ZC_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ZC_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        zc_muted = (state_q == ZC_CLOSED) || (state_q == ZC_RELEASING);
        mute_now = (state_d == ZC_CLOSED) || (state_d == ZC_RELEASING);
    end

    AST_ZC_WAIT_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !zc_muted && !in_win && !zc_clear) |=> !zc_muted); // R3
    AST_ZC_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && zc_muted && !in_win && !zc_clear) |=> zc_muted); // R4
    AST_ZC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        zc_clear |=> !zc_muted); // R5
endmodule

// File: rtl/zcm_ramp.sv
module zcm_ramp
    import zcm_pkg::*;
#(
    parameter int GAIN_W   = 8,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              req,
    input  logic              slow,
    output logic [GAIN_W-1:0] gain,
    output logic              active
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PRES_W  = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
    localparam logic [GAIN_W-1:0] G_MAX = '1;
    localparam logic [PRES_W-1:0] FAST_LAST = PRES_W'(FAST_DIV - 1);
    localparam logic [PRES_W-1:0] SLOW_LAST = PRES_W'(SLOW_DIV - 1);

    ramp_state_e       state_q, state_d;
    logic [GAIN_W-1:0] gain_q, gain_d;
    logic [PRES_W-1:0] pres_q, pres_d;
    logic [PRES_W-1:0] div_last;
    logic              ramping;
    logic              step;

    always_comb begin
        div_last = slow ? SLOW_LAST : FAST_LAST;
        ramping  = (state_q == SR_FALL) || (state_q == SR_RISE);
        step     = ramping && sample_valid && (pres_q >= div_last);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: if (req) state_d = SR_FALL;
            SR_FALL: if (!req) state_d = SR_RISE;
                     else if (step && gain_q == GAIN_W'(1)) state_d = SR_HELD;
            SR_HELD: if (!req) state_d = SR_RISE;
            SR_RISE: if (req) state_d = SR_FALL;
                     else if (step && gain_q == G_MAX - 1'b1) state_d = SR_IDLE;
            default: state_d = SR_IDLE;
        endcase
    end

    always_comb begin
        gain_d = gain_q;
        pres_d = '0;
        if (ramping && sample_valid) pres_d = step ? '0 : pres_q + 1'b1;
        else if (ramping)            pres_d = pres_q;
        if (step && state_q == SR_FALL && gain_q != '0)  gain_d = gain_q - 1'b1;
        if (step && state_q == SR_RISE && gain_q != G_MAX) gain_d = gain_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
            gain_q  <= G_MAX;
            pres_q  <= '0;
        end else begin
            state_q <= state_d;
            gain_q  <= gain_d;
            pres_q  <= pres_d;
        end
    end

    always_comb begin
        gain   = gain_q;
        active = (state_q != SR_IDLE);
    end

    AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_FALL && req) |=> (gain_q == $past(gain_q)) || (gain_q + 1'b1 == $past(gain_q))); // R7
    AST_HELD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_HELD) |-> (gain_q == '0)); // R7
    AST_IDLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_IDLE) |-> (gain_q == G_MAX)); // R8
endmodule

// File: rtl/zc_mute_ctrl.sv
module zc_mute_ctrl #(
    parameter int DATA_W   = 16,
    parameter int GAIN_W   = 8,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 64,
    parameter int WIN_BASE = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              sm_pin_n,
    input  logic              sm_req,
    input  logic              sm_slow,
    input  logic              direct_mute,
    input  logic              zc_req,
    input  logic [1:0]        win_sel,
    input  logic              zc_clear,
    output logic [DATA_W-1:0] sample_out,
    output logic              out_valid,
    output logic              sm_active,
    output logic              zc_muted
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;

    logic [1:0]              pin_sync_q;
    logic                    soft_req;
    logic                    in_win;
    logic                    zc_mute_now;
    logic [GAIN_W-1:0]       gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_sh;
    logic [DATA_W-1:0]       scaled;
    logic [DATA_W-1:0]       out_d;

    always_ff @(posedge clk) begin
        if (!rst_n) pin_sync_q <= 2'b11;
        else        pin_sync_q <= {pin_sync_q[0], sm_pin_n};
    end

    always_comb soft_req = sm_req | ~pin_sync_q[1];

    zcm_window #(.DATA_W(DATA_W), .WIN_BASE(WIN_BASE)) u_window (
        .sample  (sample_in),
        .win_sel (win_sel),
        .in_win  (in_win)
    );

    zcm_zc_fsm u_zc (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .in_win       (in_win),
        .zc_req       (zc_req),
        .zc_clear     (zc_clear),
        .zc_muted     (zc_muted),
        .mute_now     (zc_mute_now)
    );

    zcm_ramp #(.GAIN_W(GAIN_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_ramp (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .req          (soft_req),
        .slow         (sm_slow),
        .gain         (gain),
        .active       (sm_active)
    );

    always_comb begin
        prod    = PROD_W'($signed(sample_in)) * $signed({1'b0, gain});
        prod_sh = prod >>> GAIN_W;
        scaled  = prod_sh[DATA_W-1:0];
        if (direct_mute || zc_mute_now) out_d = '0;
        else if (sm_active)             out_d = scaled;
        else                            out_d = sample_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= sample_valid;
            if (sample_valid) sample_out <= out_d;
        end
    end

    AST_DIRECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && direct_mute) |=> (sample_out == '0)); // R9
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !direct_mute && !zc_mute_now && !sm_active) |=> (sample_out == $past(sample_in))); // R10
    AST_SOFT_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_req |=> sm_active); // R6
endmodule

// File: tb/zc_mute_ctrl_tb.sv
`timescale 1ns/1ps
module zc_mute_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_in = '0;
    logic        sm_pin_n = 1'b1;
    logic        sm_req = 1'b0;
    logic        sm_slow = 1'b0;
    logic        direct_mute = 1'b0;
    logic        zc_req = 1'b0;
    logic [1:0]  win_sel = 2'd0;
    logic        zc_clear = 1'b0;
    logic [15:0] sample_out;
    logic        out_valid;
    logic        sm_active;
    logic        zc_muted;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    zc_mute_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
        .sm_pin_n(sm_pin_n), .sm_req(sm_req), .sm_slow(sm_slow), .direct_mute(direct_mute),
        .zc_req(zc_req), .win_sel(win_sel), .zc_clear(zc_clear),
        .sample_out(sample_out), .out_valid(out_valid), .sm_active(sm_active), .zc_muted(zc_muted)
    );

    // {win_sel, sample, expected inside window}
    localparam logic [18:0] VEC [13] = '{
        {2'd0, 16'sd1023, 1'b1}, {2'd0, 16'sd1024, 1'b0}, {2'd0, -16'sd1023, 1'b1},
        {2'd0, -16'sd1024, 1'b0}, {2'd1, 16'sd511, 1'b1}, {2'd1, 16'sd512, 1'b0},
        {2'd2, 16'sd255, 1'b1}, {2'd2, -16'sd256, 1'b0}, {2'd3, 16'sd127, 1'b1},
        {2'd3, 16'sd128, 1'b0}, {2'd3, -16'sd128, 1'b0}, {2'd3, 16'sd0, 1'b1},
        {2'd0, 16'h8000, 1'b0}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] x);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in    = x;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        zc_clear = 1'b1;
        @(negedge clk);
        zc_clear = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sample_out == 0 && !out_valid && !sm_active && !zc_muted, "R1 reset state",
            {sample_out, out_valid, sm_active, zc_muted}, 0);
        rst_n = 1'b1;

        // R2 window table, R3 engage on inside sample
        for (int i = 0; i < 13; i++) begin
            pulse_clear();
            win_sel = VEC[i][18:17];
            zc_req  = 1'b1;
            send(VEC[i][16:1]);
            chk(zc_muted == VEC[i][0], "R2 window decision", int'(zc_muted), int'(VEC[i][0]));
            chk(sample_out == (VEC[i][0] ? 16'd0 : VEC[i][16:1]), "R3 output at crossing",
                int'($signed(sample_out)), VEC[i][0] ? 0 : int'($signed(VEC[i][16:1])));
            zc_req = 1'b0;
            pulse_clear();
        end

        // R3 deferred engage
        win_sel = 2'd0;
        zc_req  = 1'b1;
        send(16'sd3000);
        chk(!zc_muted && sample_out == 16'sd3000, "R3 wait outside window", int'($signed(sample_out)), 3000);
        send(16'sd5);
        chk(zc_muted && sample_out == 0, "R3 engage inside window", int'(zc_muted), 1);

        // R4 deferred release
        zc_req = 1'b0;
        send(16'sd3000);
        chk(zc_muted && sample_out == 0, "R4 held while outside", int'($signed(sample_out)), 0);
        send(-16'sd100);
        chk(!zc_muted && sample_out == -16'sd100, "R4 release inside window", int'($signed(sample_out)), -100);

        // R5 clear
        zc_req = 1'b1;
        send(16'sd0);
        chk(zc_muted, "R5 precondition muted", int'(zc_muted), 1);
        pulse_clear();
        chk(!zc_muted, "R5 clear unmutes", int'(zc_muted), 0);
        zc_req = 1'b0;
        pulse_clear();

        // R9 direct mute
        direct_mute = 1'b1;
        send(16'sd5000);
        chk(sample_out == 0 && !zc_muted && !sm_active, "R9 direct mute silent", int'($signed(sample_out)), 0);
        direct_mute = 1'b0;

        // R10 pass-through and valid timing
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in = -16'sd5000;
        @(negedge clk);
        sample_valid = 1'b0;
        chk(out_valid && sample_out == -16'sd5000, "R10 pass-through", int'($signed(sample_out)), -5000);
        @(negedge clk);
        chk(!out_valid, "R10 out_valid drops", int'(out_valid), 0);

        // R7 fast ramp via register
        sm_req = 1'b1;
        for (int i = 0; i < 600; i++) send(16'sd1000);
        chk(sm_active && $signed(sample_out) > 350 && $signed(sample_out) < 470, "R7 fast ramp midway",
            int'($signed(sample_out)), 410);
        for (int i = 0; i < 500; i++) send(16'sd1000);
        chk(sm_active && sample_out == 0, "R7 fast ramp silent", int'($signed(sample_out)), 0);

        // R8 release ramp
        sm_req = 1'b0;
        for (int i = 0; i < 500; i++) send(16'sd1000);
        chk(sm_active && $signed(sample_out) > 350 && $signed(sample_out) < 560, "R8 rising midway",
            int'($signed(sample_out)), 480);
        for (int i = 0; i < 600; i++) send(16'sd1000);
        chk(!sm_active && sample_out == 16'sd1000, "R8 back to full", int'($signed(sample_out)), 1000);

        // R7 slow ramp
        sm_slow = 1'b1;
        sm_req  = 1'b1;
        for (int i = 0; i < 1100; i++) send(16'sd1000);
        chk(sm_active && $signed(sample_out) > 900 && $signed(sample_out) < 950, "R7 slow ramp",
            int'($signed(sample_out)), 929);
        sm_req  = 1'b0;
        sm_slow = 1'b0;
        do_reset();

        // R6 pin request through synchroniser
        @(negedge clk);
        sm_pin_n = 1'b0;
        @(negedge clk);
        chk(!sm_active, "R6 pin not yet through sync", int'(sm_active), 0);
        repeat (3) @(negedge clk);
        chk(sm_active, "R6 pin engages soft mute", int'(sm_active), 1);
        for (int i = 0; i < 1100; i++) send(-16'sd1000);
        chk(sample_out == 0, "R6 pin ramp silent", int'($signed(sample_out)), 0);
        sm_pin_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule